// File: doc/BRIEF.md
# Exception Cause and Vector Unit

This unit sits beside the program counter logic of a small multi-cycle processor. It watches two trap lines from the executing instruction (undefined opcode and arithmetic overflow), one external interrupt request line, and a return-from-exception strobe. When it accepts an exception, it raises a redirect in the same cycle and presents the handler entry address as the next PC. On the following clock edge it records a cause code, copies the faulting PC into a dedicated exception-PC register, enters kernel mode and masks interrupts.

The handler entry comes from one of two addressing schemes, selected by an input. Fixed mode sends every exception to one entry point. Vectored mode gives each cause its own slot of 32 instructions. A return strobe issued in kernel mode does three things in one cycle: it redirects to the saved PC, restores the mode that was active before the exception, and re-enables interrupts.

The mode is held by a two-state machine. `ST_USER` moves to `ST_KERNEL` on any accepted exception (transition TAKE). `ST_KERNEL` stays in `ST_KERNEL` on a further exception (transition NEST). `ST_KERNEL` goes to the saved previous mode on a return (transition RETURN), which may be `ST_USER` or `ST_KERNEL`.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset the unit is in user mode with interrupts enabled. Cause is 0, the exception PC is 0, the nested flag and the pending flag are clear, and no redirect is driven.
- R2: An accepted exception drives `redirect_o` high in the same cycle. From the next cycle, `epc_o` holds that cycle's `pc_i`, `kernel_o` is 1 and `int_en_o` is 0.
- R3: Cause codes are 0 for undefined instruction, 1 for arithmetic overflow and 2 for external interrupt. When both trap lines are high, undefined instruction wins. Priority order is traps, then return, then interrupt.
- R4: With `vec_mode_i` = 0, the exception target is 0x80000080 for every cause.
- R5: With `vec_mode_i` = 1, the exception target is 0x80 + (cause << 7), which gives 0x80, 0x100 and 0x180.
- R6: `eret_i` in kernel mode with no trap drives a redirect to `epc_o` in the same cycle. On the next edge it restores the previous mode and sets `int_en_o` to 1.
- R7: `eret_i` in user mode is ignored: no redirect, and mode, interrupt enable, cause and exception PC are unchanged.
- R8: With interrupts enabled, an interrupt request with no trap is taken at once. With interrupts disabled, it is latched in `irq_pending_o` and not taken. It is taken as soon as interrupts are enabled again, and the pending flag then clears.
- R9: An exception accepted while already in kernel mode sets `nested_o`, which stays set until reset. A later return then keeps kernel mode.
- R10: `target_o` is 0 whenever `redirect_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | PC of the instruction in the current cycle |
| trap_undef_i | input | 1 | Undefined-instruction trap |
| trap_ovf_i | input | 1 | Arithmetic-overflow trap |
| irq_i | input | 1 | External interrupt request |
| eret_i | input | 1 | Return-from-exception strobe |
| vec_mode_i | input | 1 | 0 = fixed entry, 1 = vectored entry |
| redirect_o | output | 1 | Next PC must be taken from target_o |
| target_o | output | 32 | Redirect address |
| epc_o | output | 32 | Saved exception PC |
| cause_o | output | 2 | Recorded cause code |
| kernel_o | output | 1 | 1 in kernel mode |
| int_en_o | output | 1 | Interrupt enable |
| irq_pending_o | output | 1 | Interrupt held while masked |
| nested_o | output | 1 | Sticky nested-exception flag |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, a fixed entry of 0x80000080, a vector origin of 0x80, a slot shift of 7, and the vectored variant enabled. These values put all three vectored slots and the fixed entry in range of one run. The bench can therefore compare exact handler addresses for every cause in both modes. It also walks the masked-interrupt path from latch to delayed acceptance, and the nested path in which a return keeps kernel mode.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Recorded cause codes
    typedef enum logic [1:0] {
        CAUSE_UNDEF = 2'd0,
        CAUSE_OVF   = 2'd1,
        CAUSE_IRQ   = 2'd2
    } cause_e;

    // Privilege state of the control machine
    typedef enum logic {
        ST_USER   = 1'b0,
        ST_KERNEL = 1'b1
    } mode_e;

    // Event selected by the arbiter in a cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_RET  = 2'd2
    } event_e;

    localparam int CAUSE_W = 2;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic   undef_i,
    input  logic   ovf_i,
    input  logic   irq_req_i,
    input  logic   eret_i,
    input  logic   int_en_i,
    input  logic   in_kernel_i,
    output event_e ev_o,
    output cause_e code_o
);

    // Fixed priority: undefined > overflow > return > interrupt
    always_comb begin
        ev_o   = EV_NONE;
        code_o = CAUSE_UNDEF;
        if (undef_i) begin
            ev_o   = EV_EXC;
            code_o = CAUSE_UNDEF;
        end else if (ovf_i) begin
            ev_o   = EV_EXC;
            code_o = CAUSE_OVF;
        end else if (eret_i && in_kernel_i) begin
            ev_o   = EV_RET;
        end else if (irq_req_i && int_en_i) begin
            ev_o   = EV_EXC;
            code_o = CAUSE_IRQ;
        end
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] FIXED_ENTRY  = 32'h8000_0080,
    parameter logic [ADDR_W-1:0] VEC_ORIGIN   = 32'h0000_0080,
    parameter int                SLOT_SHIFT   = 7,
    parameter bit                HAS_VECTORED = 1'b1
) (
    input  logic              vec_mode_i,
    input  event_e            ev_i,
    input  cause_e            code_i,
    input  logic [ADDR_W-1:0] epc_i,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] target_o
);

    localparam int PAD_W = ADDR_W - CAUSE_W;

    logic [ADDR_W-1:0] entry;

    generate
        if (HAS_VECTORED) begin : g_vectored
            logic [ADDR_W-1:0] slot_off;
            assign slot_off = {{PAD_W{1'b0}}, code_i} << SLOT_SHIFT;
            assign entry    = vec_mode_i ? (VEC_ORIGIN + slot_off) : FIXED_ENTRY;
        end else begin : g_fixed
            logic unused_sel;
            assign unused_sel = vec_mode_i ^ (^code_i);
            assign entry      = FIXED_ENTRY;
        end
    endgenerate

    always_comb begin
        redirect_o = 1'b0;
        target_o   = '0;
        case (ev_i)
            EV_EXC: begin
                redirect_o = 1'b1;
                target_o   = entry;
            end
            EV_RET: begin
                redirect_o = 1'b1;
                target_o   = epc_i;
            end
            default: begin
                redirect_o = 1'b0;
                target_o   = '0;
            end
        endcase
    end

endmodule

// File: rtl/exc_ctrl_fsm.sv
module exc_ctrl_fsm
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              irq_i,
    input  event_e            ev_i,
    input  cause_e            code_i,
    output logic              kernel_o,
    output logic              int_en_o,
    output logic              pending_o,
    output logic              nested_o,
    output logic [ADDR_W-1:0] epc_o,
    output cause_e            cause_o
);

    mode_e             state_q, state_d;
    mode_e             prev_q,  prev_d;
    logic              ie_q,    ie_d;
    logic              pend_q,  pend_d;
    logic              nest_q,  nest_d;
    logic [ADDR_W-1:0] epc_q,   epc_d;
    cause_e            cause_q, cause_d;
    logic              take_irq;

    assign take_irq = (ev_i == EV_EXC) && (code_i == CAUSE_IRQ);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_USER;
            prev_q  <= ST_USER;
            ie_q    <= 1'b1;
            pend_q  <= 1'b0;
            nest_q  <= 1'b0;
            epc_q   <= '0;
            cause_q <= CAUSE_UNDEF;
        end else begin
            state_q <= state_d;
            prev_q  <= prev_d;
            ie_q    <= ie_d;
            pend_q  <= pend_d;
            nest_q  <= nest_d;
            epc_q   <= epc_d;
            cause_q <= cause_d;
        end
    end

    // Next state and status updates
    always_comb begin
        state_d = state_q;
        prev_d  = prev_q;
        ie_d    = ie_q;
        nest_d  = nest_q;
        epc_d   = epc_q;
        cause_d = cause_q;
        pend_d  = (pend_q | irq_i) & ~take_irq;
        unique case (state_q)
            ST_USER: begin
                if (ev_i == EV_EXC) begin          // TAKE
                    state_d = ST_KERNEL;
                    prev_d  = ST_USER;
                    ie_d    = 1'b0;
                    epc_d   = pc_i;
                    cause_d = code_i;
                end
            end
            ST_KERNEL: begin
                if (ev_i == EV_EXC) begin          // NEST
                    state_d = ST_KERNEL;
                    prev_d  = ST_KERNEL;
                    ie_d    = 1'b0;
                    nest_d  = 1'b1;
                    epc_d   = pc_i;
                    cause_d = code_i;
                end else if (ev_i == EV_RET) begin // RETURN
                    state_d = prev_q;
                    ie_d    = 1'b1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        kernel_o  = (state_q == ST_KERNEL);
        int_en_o  = ie_q;
        pending_o = pend_q;
        nested_o  = nest_q;
        epc_o     = epc_q;
        cause_o   = cause_q;
    end

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] FIXED_ENTRY  = 32'h8000_0080,
    parameter logic [ADDR_W-1:0] VEC_ORIGIN   = 32'h0000_0080,
    parameter int                SLOT_SHIFT   = 7,
    parameter bit                HAS_VECTORED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              trap_undef_i,
    input  logic              trap_ovf_i,
    input  logic              irq_i,
    input  logic              eret_i,
    input  logic              vec_mode_i,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] target_o,
    output logic [ADDR_W-1:0] epc_o,
    output logic [1:0]        cause_o,
    output logic              kernel_o,
    output logic              int_en_o,
    output logic              irq_pending_o,
    output logic              nested_o
);

    event_e ev;
    cause_e code;
    cause_e cause_rec;

    exc_arbiter u_arb (
        .undef_i     (trap_undef_i),
        .ovf_i       (trap_ovf_i),
        .irq_req_i   (irq_i | irq_pending_o),
        .eret_i      (eret_i),
        .int_en_i    (int_en_o),
        .in_kernel_i (kernel_o),
        .ev_o        (ev),
        .code_o      (code)
    );

    exc_vector_gen #(
        .ADDR_W       (ADDR_W),
        .FIXED_ENTRY  (FIXED_ENTRY),
        .VEC_ORIGIN   (VEC_ORIGIN),
        .SLOT_SHIFT   (SLOT_SHIFT),
        .HAS_VECTORED (HAS_VECTORED)
    ) u_vec (
        .vec_mode_i (vec_mode_i),
        .ev_i       (ev),
        .code_i     (code),
        .epc_i      (epc_o),
        .redirect_o (redirect_o),
        .target_o   (target_o)
    );

    exc_ctrl_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_i      (pc_i),
        .irq_i     (irq_i),
        .ev_i      (ev),
        .code_i    (code),
        .kernel_o  (kernel_o),
        .int_en_o  (int_en_o),
        .pending_o (irq_pending_o),
        .nested_o  (nested_o),
        .epc_o     (epc_o),
        .cause_o   (cause_rec)
    );

    assign cause_o = cause_rec;

endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] FIXED_ENTRY = 32'h8000_0080,
    parameter logic [ADDR_W-1:0] VEC_ORIGIN  = 32'h0000_0080
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc_i,
    input logic              trap_undef_i,
    input logic              trap_ovf_i,
    input logic              irq_i,
    input logic              eret_i,
    input logic              vec_mode_i,
    input logic              redirect_o,
    input logic [ADDR_W-1:0] target_o,
    input logic [ADDR_W-1:0] epc_o,
    input logic [1:0]        cause_o,
    input logic              kernel_o,
    input logic              int_en_o,
    input logic              irq_pending_o,
    input logic              nested_o
);

    logic trap;
    assign trap = trap_undef_i | trap_ovf_i;

    // R2
    trap_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (kernel_o && !int_en_o && epc_o == $past(pc_i)));

    // R3
    undef_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_undef_i |=> (cause_o == 2'd0));

    // R4
    fixed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !vec_mode_i) |-> (redirect_o && target_o == FIXED_ENTRY));

    // R5
    undef_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_undef_i && vec_mode_i) |-> (target_o == VEC_ORIGIN));

    // R6
    eret_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && kernel_o && !trap) |-> (redirect_o && target_o == epc_o));

    // R6
    eret_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && kernel_o && !trap) |=> int_en_o);

    // R7
    eret_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !kernel_o && !trap && !irq_i && !irq_pending_o) |-> !redirect_o);

    // R8
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en_o && !trap && !eret_i) |-> !redirect_o);

    // R8
    pending_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending_o && int_en_o && !trap && !eret_i) |-> redirect_o);

    // R9
    nested_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nested_o |=> nested_o);

    // R10
    idle_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |-> (target_o == '0));

endmodule

bind exc_vector_unit exc_vector_unit_chk #(
    .ADDR_W      (ADDR_W),
    .FIXED_ENTRY (FIXED_ENTRY),
    .VEC_ORIGIN  (VEC_ORIGIN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_i          (pc_i),
    .trap_undef_i  (trap_undef_i),
    .trap_ovf_i    (trap_ovf_i),
    .irq_i         (irq_i),
    .eret_i        (eret_i),
    .vec_mode_i    (vec_mode_i),
    .redirect_o    (redirect_o),
    .target_o      (target_o),
    .epc_o         (epc_o),
    .cause_o       (cause_o),
    .kernel_o      (kernel_o),
    .int_en_o      (int_en_o),
    .irq_pending_o (irq_pending_o),
    .nested_o      (nested_o)
);

// File: tb/exc_vector_unit_test.sv
module exc_vector_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic        trap_undef_i = 1'b0;
    logic        trap_ovf_i = 1'b0;
    logic        irq_i = 1'b0;
    logic        eret_i = 1'b0;
    logic        vec_mode_i = 1'b0;
    logic        redirect_o;
    logic [31:0] target_o;
    logic [31:0] epc_o;
    logic [1:0]  cause_o;
    logic        kernel_o;
    logic        int_en_o;
    logic        irq_pending_o;
    logic        nested_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    exc_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i),
        .trap_undef_i(trap_undef_i), .trap_ovf_i(trap_ovf_i),
        .irq_i(irq_i), .eret_i(eret_i), .vec_mode_i(vec_mode_i),
        .redirect_o(redirect_o), .target_o(target_o), .epc_o(epc_o),
        .cause_o(cause_o), .kernel_o(kernel_o), .int_en_o(int_en_o),
        .irq_pending_o(irq_pending_o), .nested_o(nested_o)
    );

    // Row: pc, undef, ovf, irq, eret, vmode, exp_redir, exp_tgt,
    //      exp_kernel, exp_ie, exp_cause, exp_epc  (106 bits)
    localparam int NROWS = 10;
    localparam logic [105:0] TBL [0:NROWS-1] = '{
        {32'h0000_1000, 5'b10000, 1'b1, 32'h8000_0080, 1'b1, 1'b0, 2'd0, 32'h0000_1000},
        {32'h8000_0080, 5'b00010, 1'b1, 32'h0000_1000, 1'b0, 1'b1, 2'd0, 32'h0000_1000},
        {32'h0000_1004, 5'b01001, 1'b1, 32'h0000_0100, 1'b1, 1'b0, 2'd1, 32'h0000_1004},
        {32'h0000_0100, 5'b00001, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd1, 32'h0000_1004},
        {32'h0000_0104, 5'b00011, 1'b1, 32'h0000_1004, 1'b0, 1'b1, 2'd1, 32'h0000_1004},
        {32'h0000_2000, 5'b11001, 1'b1, 32'h0000_0080, 1'b1, 1'b0, 2'd0, 32'h0000_2000},
        {32'h0000_0084, 5'b00011, 1'b1, 32'h0000_2000, 1'b0, 1'b1, 2'd0, 32'h0000_2000},
        {32'h0000_3000, 5'b00101, 1'b1, 32'h0000_0180, 1'b1, 1'b0, 2'd2, 32'h0000_3000},
        {32'h0000_0180, 5'b00011, 1'b1, 32'h0000_3000, 1'b0, 1'b1, 2'd2, 32'h0000_3000},
        {32'h0000_3004, 5'b00010, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 2'd2, 32'h0000_3000}
    };

    function automatic string row_tag(int i);
        case (i)
            0: return "R4";
            1: return "R6";
            2: return "R5";
            3: return "R10";
            4: return "R6";
            5: return "R3";
            6: return "R6";
            7: return "R8";
            8: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] pc, logic u, logic o, logic q, logic e, logic vm);
        pc_i = pc; trap_undef_i = u; trap_ovf_i = o; irq_i = q; eret_i = e; vec_mode_i = vm;
    endtask

    // advance past the next rising edge, sample, then realign to falling edge
    task automatic tick();
        @(posedge clk); #5;
    endtask

    task automatic realign();
        @(negedge clk);
    endtask

    task automatic check_reset_state(string tag);
        check({tag, " kernel"},  {31'd0, kernel_o}, 32'd0);
        check({tag, " ie"},      {31'd0, int_en_o}, 32'd1);
        check({tag, " cause"},   {30'd0, cause_o}, 32'd0);
        check({tag, " epc"},     epc_o, 32'd0);
        check({tag, " nested"},  {31'd0, nested_o}, 32'd0);
        check({tag, " pending"}, {31'd0, irq_pending_o}, 32'd0);
        check({tag, " redirect"},{31'd0, redirect_o}, 32'd0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        check_reset_state("R1");
        realign();

        // Table walk
        for (int i = 0; i < NROWS; i++) begin
            logic [105:0] r;
            r = TBL[i];
            drive(r[105:74], r[73], r[72], r[71], r[70], r[69]);
            #5;
            check({row_tag(i), " redirect"}, {31'd0, redirect_o}, {31'd0, r[68]});
            check({row_tag(i), " target"},   target_o, r[67:36]);
            tick();
            check({row_tag(i), " R2 kernel"}, {31'd0, kernel_o}, {31'd0, r[35]});
            check({row_tag(i), " R2 ie"},     {31'd0, int_en_o}, {31'd0, r[34]});
            check({row_tag(i), " cause"},     {30'd0, cause_o}, {30'd0, r[33:32]});
            check({row_tag(i), " R2 epc"},    epc_o, r[31:0]);
            realign();
        end

        // R8: interrupt held while masked
        drive(32'h0000_4000, 1, 0, 0, 0, 1); #5;
        check("R2 undef redirect", {31'd0, redirect_o}, 32'd1);
        tick(); realign();
        drive(32'h8000_0080, 0, 0, 1, 0, 1); #5;
        check("R8 masked no redirect", {31'd0, redirect_o}, 32'd0);
        tick();
        check("R8 pending set", {31'd0, irq_pending_o}, 32'd1);
        realign();
        drive(32'h8000_0084, 0, 0, 0, 0, 1); #5;
        check("R8 still masked", {31'd0, redirect_o}, 32'd0);
        tick();
        check("R8 pending held", {31'd0, irq_pending_o}, 32'd1);
        realign();
        drive(32'h8000_0088, 0, 0, 0, 1, 1); #5;
        check("R6 eret target", target_o, 32'h0000_4000);
        tick();
        check("R6 back to user", {31'd0, kernel_o}, 32'd0);
        check("R8 pending over eret", {31'd0, irq_pending_o}, 32'd1);
        realign();
        drive(32'h0000_4000, 0, 0, 0, 0, 1); #5;
        check("R8 deferred redirect", {31'd0, redirect_o}, 32'd1);
        check("R5 irq slot", target_o, 32'h0000_0180);
        tick();
        check("R8 pending cleared", {31'd0, irq_pending_o}, 32'd0);
        check("R3 irq cause", {30'd0, cause_o}, 32'd2);
        check("R2 irq epc", epc_o, 32'h0000_4000);
        realign();
        drive(32'h0000_0180, 0, 0, 0, 1, 1); tick(); realign();

        // R9: nested exception
        drive(32'h0000_5000, 1, 0, 0, 0, 0); tick();
        check("R9 not nested yet", {31'd0, nested_o}, 32'd0);
        realign();
        drive(32'h8000_0080, 0, 1, 0, 0, 0); #5;
        check("R4 nested target", target_o, 32'h8000_0080);
        tick();
        check("R9 nested set", {31'd0, nested_o}, 32'd1);
        check("R3 ovf cause", {30'd0, cause_o}, 32'd1);
        realign();
        drive(32'h8000_0090, 0, 0, 0, 1, 0); #5;
        check("R6 nested eret target", target_o, 32'h8000_0080);
        tick();
        check("R9 stays kernel", {31'd0, kernel_o}, 32'd1);
        check("R6 ie restored", {31'd0, int_en_o}, 32'd1);
        realign();
        drive(32'h8000_0094, 0, 0, 0, 0, 0); #5;
        check("R10 idle target", target_o, 32'd0);
        tick();
        check("R9 nested sticky", {31'd0, nested_o}, 32'd1);
        realign();

        // R1: reset clears everything
        rst_n = 1'b0;
        tick(); realign();
        rst_n = 1'b1;
        #5;
        check_reset_state("R1 rerun");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule